// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a one-way first-in first-out buffer of 64 words of 36 bits. A producer writes on one clock and a consumer reads on a second clock that has no fixed relation to the first. Each side sees only the status flags it needs. The flags are active low and are computed in that side's own clock domain. The write side has full and almost-full. The read side has empty and almost-empty.

The two sides exchange pointers as Gray code through two-stage synchronizers. Each flag is therefore pessimistic: it can report a fuller or emptier state than the real one, but never a wrong safe state. The threshold for both almost-flags comes from a two-bit select input. That input is sampled while reset is held and stays fixed once reset is released. Each port has an active-low select and an active-high enable, and both must be true for a transfer. The read data sits in an output register that changes only when a read is accepted.

Top module: `dcfifo_flagged`

## Requirements
- R1: A word is stored on a rising `clk_w` edge only when `w_cs_n` is 0, `w_en` is 1 and `full_n` is 1. A word is taken on a rising `clk_r` edge only when `r_cs_n` is 0, `r_en` is 1 and `empty_n` is 1. An attempt with the select high or the enable low changes nothing.
- R2: Words come out in the order they were stored. `r_data` takes the new word on the accepting `clk_r` edge and otherwise holds its value.
- R3: While `rst` is 1, all four flags are 0 and `r_data` is 0. After `rst` falls, `full_n` is still 0 after the first `clk_w` edge and is 1 after the second. The FIFO then holds no words.
- R4: `full_n` is 0 right after the edge that stores the 64th word. Further writes are dropped, so no stored word is overwritten.
- R5: `empty_n` is 0 right after the edge that takes the last word the read side knows of. A read attempt while `empty_n` is 0 leaves `r_data` unchanged.
- R6: After a word is written into an empty FIFO, `empty_n` is still 0 after the first following `clk_r` edge and is 1 after the second.
- R7: `aempty_n` is 0 when the word count seen by the read side is at or below the threshold X, and 1 above it.
- R8: `afull_n` is 0 when the free space seen by the write side (64 minus the count) is at or below X, and 1 above it.
- R9: X is selected by `ofs_sel` as follows: 00 gives 16, 01 gives 12, 10 gives 8 and 11 gives 4. The value is taken while reset is held. A change of `ofs_sel` after reset has no effect.
- R10: After a read frees a slot in a full FIFO, `full_n` is still 0 after the first following `clk_w` edge and is 1 after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_w | input | 1 | Write-side clock |
| clk_r | input | 1 | Read-side clock |
| rst | input | 1 | Active-high reset, asserted asynchronously, released per domain |
| ofs_sel | input | 2 | Almost-flag threshold code, sampled during reset |
| w_cs_n | input | 1 | Write port select, active low |
| w_en | input | 1 | Write enable, active high |
| w_data | input | 36 | Word to store |
| full_n | output | 1 | Low when no free slot (write domain) |
| afull_n | output | 1 | Low when free slots are at or below X (write domain) |
| r_cs_n | input | 1 | Read port select, active low |
| r_en | input | 1 | Read enable, active high |
| r_data | output | 36 | Registered output word |
| empty_n | output | 1 | Low when no word is stored (read domain) |
| aempty_n | output | 1 | Low when stored words are at or below X (read domain) |

## Verification
Several results appear at the same edge as the transfer that causes them. These are the new `r_data`, the fall of `empty_n` after the last read, the fall of `full_n` and `afull_n` on a write, and the change in `aempty_n` on a read. Other results depend on the far side and appear only after the second edge of the observing clock. These are the rise of `empty_n` after a write and the rise of `full_n` after reset or after a read. The two clocks are chosen so that their rising edges are always at least 0.5 ns apart. Every check samples 0.2 ns after a named edge, so the first and second observing edges can be told apart without ambiguity. A scoreboard queue collects the accepted writes, and a monitor compares each accepted read against it at the accepting edge.

// File: rtl/fifo_pkg.sv
`timescale 1ns/1ps
package fifo_pkg;

    typedef enum logic [1:0] {
        OFS_L0 = 2'b00,
        OFS_L1 = 2'b01,
        OFS_L2 = 2'b10,
        OFS_L3 = 2'b11
    } ofs_code_t;

    typedef struct packed {
        logic sel_n;
        logic go;
    } port_ctl_t;

    function automatic int unsigned pick_offset(input ofs_code_t c,
                                                input int unsigned base,
                                                input int unsigned step);
        case (c)
            OFS_L0:  return base;
            OFS_L1:  return base - step;
            OFS_L2:  return base - 2 * step;
            default: return base - 3 * step;
        endcase
    endfunction

endpackage

// File: rtl/fifo_cdc.sv
`timescale 1ns/1ps
module fifo_cdc #(
    parameter int unsigned W        = 1,
    parameter int unsigned STAGES   = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         arst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/fifo_ram.sv
`timescale 1ns/1ps
module fifo_ram #(
    parameter int unsigned DATA_W = 36,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/fifo_wr_ctl.sv
`timescale 1ns/1ps
module fifo_wr_ctl
    import fifo_pkg::*;
#(
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned OFS_BASE = 16,
    parameter int unsigned OFS_STEP = 4
) (
    input  logic              clk,
    input  logic              lrst,
    input  port_ctl_t         ctl,
    input  logic [1:0]        ofs_sel,
    input  logic [ADDR_W:0]   rgray_s,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wptr,
    output logic [ADDR_W:0]   wgray,
    output logic              full_n,
    output logic              afull_n
);
    localparam int unsigned PTR_W = ADDR_W + 1;
    localparam int unsigned DEPTH = 1 << ADDR_W;

    function automatic logic [PTR_W-1:0] b2g(input logic [PTR_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PTR_W-1:0] g2b(input logic [PTR_W-1:0] g);
        logic [PTR_W-1:0] b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [PTR_W-1:0] ofs;
    logic [PTR_W-1:0] rbin;
    logic [PTR_W-1:0] used;
    logic [PTR_W-1:0] nxt;

    always_ff @(posedge clk) begin
        if (lrst) ofs <= PTR_W'(pick_offset(ofs_code_t'(ofs_sel), OFS_BASE, OFS_STEP));
    end

    assign rbin = g2b(rgray_s);
    assign used = wptr - rbin;
    assign nxt  = wptr + PTR_W'(1);
    assign we   = ~ctl.sel_n & ctl.go & full_n;

    always_ff @(posedge clk or posedge lrst) begin
        if (lrst) begin
            wptr  <= '0;
            wgray <= '0;
        end else if (we) begin
            wptr  <= nxt;
            wgray <= b2g(nxt);
        end
    end

    assign waddr   = wptr[ADDR_W-1:0];
    assign full_n  = ~lrst & (used != PTR_W'(DEPTH));
    assign afull_n = ~lrst & ((PTR_W'(DEPTH) - used) > ofs);
endmodule

// File: rtl/fifo_rd_ctl.sv
`timescale 1ns/1ps
module fifo_rd_ctl
    import fifo_pkg::*;
#(
    parameter int unsigned DATA_W   = 36,
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned OFS_BASE = 16,
    parameter int unsigned OFS_STEP = 4
) (
    input  logic              clk,
    input  logic              lrst,
    input  port_ctl_t         ctl,
    input  logic [1:0]        ofs_sel,
    input  logic [ADDR_W:0]   wgray_s,
    input  logic [DATA_W-1:0] ram_q,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rptr,
    output logic [ADDR_W:0]   rgray,
    output logic [DATA_W-1:0] rdata,
    output logic              empty_n,
    output logic              aempty_n
);
    localparam int unsigned PTR_W = ADDR_W + 1;

    function automatic logic [PTR_W-1:0] b2g(input logic [PTR_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PTR_W-1:0] g2b(input logic [PTR_W-1:0] g);
        logic [PTR_W-1:0] b;
        b[PTR_W-1] = g[PTR_W-1];
        for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    logic [PTR_W-1:0] ofs;
    logic [PTR_W-1:0] wbin;
    logic [PTR_W-1:0] used;
    logic [PTR_W-1:0] nxt;
    logic             re;

    always_ff @(posedge clk) begin
        if (lrst) ofs <= PTR_W'(pick_offset(ofs_code_t'(ofs_sel), OFS_BASE, OFS_STEP));
    end

    assign wbin = g2b(wgray_s);
    assign used = wbin - rptr;
    assign nxt  = rptr + PTR_W'(1);
    assign re   = ~ctl.sel_n & ctl.go & empty_n;

    always_ff @(posedge clk or posedge lrst) begin
        if (lrst) begin
            rptr  <= '0;
            rgray <= '0;
            rdata <= '0;
        end else if (re) begin
            rptr  <= nxt;
            rgray <= b2g(nxt);
            rdata <= ram_q;
        end
    end

    assign raddr    = rptr[ADDR_W-1:0];
    assign empty_n  = ~lrst & (used != '0);
    assign aempty_n = ~lrst & (used > ofs);
endmodule

// File: rtl/dcfifo_flagged.sv
`timescale 1ns/1ps
module dcfifo_flagged
    import fifo_pkg::*;
#(
    parameter int unsigned DATA_W   = 36,
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned OFS_BASE = 16,
    parameter int unsigned OFS_STEP = 4,
    parameter int unsigned SYNC_N   = 2
) (
    input  logic              clk_w,
    input  logic              clk_r,
    input  logic              rst,
    input  logic [1:0]        ofs_sel,
    input  logic              w_cs_n,
    input  logic              w_en,
    input  logic [DATA_W-1:0] w_data,
    output logic              full_n,
    output logic              afull_n,
    input  logic              r_cs_n,
    input  logic              r_en,
    output logic [DATA_W-1:0] r_data,
    output logic              empty_n,
    output logic              aempty_n
);
    localparam int unsigned PTR_W = ADDR_W + 1;

    logic              w_lrst, r_lrst;
    port_ctl_t         w_ctl, r_ctl;
    logic [PTR_W-1:0]  w_ptr, w_gray, w_gray_s;
    logic [PTR_W-1:0]  r_ptr, r_gray, r_gray_s;
    logic [ADDR_W-1:0] w_addr, r_addr;
    logic              w_we;
    logic [DATA_W-1:0] ram_q;

    assign w_ctl.sel_n = w_cs_n;
    assign w_ctl.go    = w_en;
    assign r_ctl.sel_n = r_cs_n;
    assign r_ctl.go    = r_en;

    fifo_cdc #(.W(1), .STAGES(SYNC_N), .RST_VAL(1'b1)) u_wrst (
        .clk(clk_w), .arst(rst), .d(1'b0), .q(w_lrst)
    );
    fifo_cdc #(.W(1), .STAGES(SYNC_N), .RST_VAL(1'b1)) u_rrst (
        .clk(clk_r), .arst(rst), .d(1'b0), .q(r_lrst)
    );

    fifo_cdc #(.W(PTR_W), .STAGES(SYNC_N), .RST_VAL({PTR_W{1'b0}})) u_r2w (
        .clk(clk_w), .arst(w_lrst), .d(r_gray), .q(r_gray_s)
    );
    fifo_cdc #(.W(PTR_W), .STAGES(SYNC_N), .RST_VAL({PTR_W{1'b0}})) u_w2r (
        .clk(clk_r), .arst(r_lrst), .d(w_gray), .q(w_gray_s)
    );

    fifo_wr_ctl #(.ADDR_W(ADDR_W), .OFS_BASE(OFS_BASE), .OFS_STEP(OFS_STEP)) u_wr (
        .clk(clk_w), .lrst(w_lrst), .ctl(w_ctl), .ofs_sel(ofs_sel),
        .rgray_s(r_gray_s), .we(w_we), .waddr(w_addr), .wptr(w_ptr),
        .wgray(w_gray), .full_n(full_n), .afull_n(afull_n)
    );

    fifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .wclk(clk_w), .we(w_we), .waddr(w_addr), .wdata(w_data),
        .raddr(r_addr), .rdata(ram_q)
    );

    fifo_rd_ctl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS_BASE(OFS_BASE), .OFS_STEP(OFS_STEP)) u_rd (
        .clk(clk_r), .lrst(r_lrst), .ctl(r_ctl), .ofs_sel(ofs_sel),
        .wgray_s(w_gray_s), .ram_q(ram_q), .raddr(r_addr), .rptr(r_ptr),
        .rgray(r_gray), .rdata(r_data), .empty_n(empty_n), .aempty_n(aempty_n)
    );
endmodule

// File: rtl/fifo_flag_checker.sv
`timescale 1ns/1ps
module fifo_flag_checker #(
    parameter int unsigned PTR_W  = 7,
    parameter int unsigned DATA_W = 36
) (
    input logic              clk_w,
    input logic              clk_r,
    input logic              w_lrst,
    input logic              r_lrst,
    input logic              w_cs_n,
    input logic              w_en,
    input logic              r_cs_n,
    input logic              r_en,
    input logic              full_n,
    input logic              afull_n,
    input logic              empty_n,
    input logic              aempty_n,
    input logic [PTR_W-1:0]  w_ptr,
    input logic [PTR_W-1:0]  r_ptr,
    input logic [DATA_W-1:0] r_data
);
    // R1: a write attempt without select and enable leaves the write pointer alone
    a_r1_gated_write: assert property (@(posedge clk_w) disable iff (w_lrst)
        (w_cs_n || !w_en) |=> $stable(w_ptr));

    // R2: output register only moves on an accepted read
    a_r2_rdata_hold: assert property (@(posedge clk_r) disable iff (r_lrst)
        (r_cs_n || !r_en || !empty_n) |=> $stable(r_data));

    // R4: no pointer advance while full
    a_r4_no_overflow: assert property (@(posedge clk_w) disable iff (w_lrst)
        (!full_n && !w_cs_n && w_en) |=> $stable(w_ptr));

    // R5: no pointer advance while empty
    a_r5_no_underflow: assert property (@(posedge clk_r) disable iff (r_lrst)
        (!empty_n && !r_cs_n && r_en) |=> $stable(r_ptr));

    // R8: full is always inside the almost-full region
    a_r8_full_in_afull: assert property (@(posedge clk_w) disable iff (w_lrst)
        !full_n |-> !afull_n);

    // R7: empty is always inside the almost-empty region
    a_r7_empty_in_aempty: assert property (@(posedge clk_r) disable iff (r_lrst)
        !empty_n |-> !aempty_n);

    // R3: flags held low while each domain is in reset
    always @(posedge clk_w) begin
        if (w_lrst === 1'b1) begin
            a_r3_wr_reset_low: assert (!full_n && !afull_n)
                else $error("write flags high during reset");
        end
    end

    always @(posedge clk_r) begin
        if (r_lrst === 1'b1) begin
            a_r3_rd_reset_low: assert (!empty_n && !aempty_n)
                else $error("read flags high during reset");
        end
    end
endmodule

bind dcfifo_flagged fifo_flag_checker #(.PTR_W(ADDR_W + 1), .DATA_W(DATA_W)) u_chk (
    .clk_w(clk_w), .clk_r(clk_r), .w_lrst(w_lrst), .r_lrst(r_lrst),
    .w_cs_n(w_cs_n), .w_en(w_en), .r_cs_n(r_cs_n), .r_en(r_en),
    .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n),
    .w_ptr(w_ptr), .r_ptr(r_ptr), .r_data(r_data)
);

// File: tb/sim_dcfifo_flagged.sv
`timescale 1ns/1ps
module sim_dcfifo_flagged;
    logic        clk_w = 1'b0;
    logic        clk_r = 1'b0;
    logic        rst   = 1'b1;
    logic [1:0]  ofs_sel = 2'b00;
    logic        w_cs_n = 1'b1;
    logic        w_en   = 1'b0;
    logic [35:0] w_data = '0;
    logic        r_cs_n = 1'b1;
    logic        r_en   = 1'b0;
    logic        full_n, afull_n, empty_n, aempty_n;
    logic [35:0] r_data;

    int n_chk  = 0;
    int n_fail = 0;
    logic [35:0] exp_q [$];

    always #2.5 clk_w = ~clk_w;   // 200 MHz, rising at 2.5 + 5k
    always #4   clk_r = ~clk_r;   // rising at 4 + 8k, never within 0.5 ns of clk_w

    dcfifo_flagged u0 (
        .clk_w(clk_w), .clk_r(clk_r), .rst(rst), .ofs_sel(ofs_sel),
        .w_cs_n(w_cs_n), .w_en(w_en), .w_data(w_data),
        .full_n(full_n), .afull_n(afull_n),
        .r_cs_n(r_cs_n), .r_en(r_en), .r_data(r_data),
        .empty_n(empty_n), .aempty_n(aempty_n)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [35:0] d, input logic cs_n, input logic en);
        @(negedge clk_w);
        w_data = d; w_cs_n = cs_n; w_en = en;
        if (!cs_n && en && full_n) exp_q.push_back(d);
        @(posedge clk_w); #0.2;
        w_cs_n = 1'b1; w_en = 1'b0;
    endtask

    task automatic rd();
        @(negedge clk_r);
        r_cs_n = 1'b0; r_en = 1'b1;
        @(posedge clk_r); #0.2;
        r_cs_n = 1'b1; r_en = 1'b0;
    endtask

    task automatic do_reset(input logic [1:0] sel);
        @(negedge clk_w);
        rst = 1'b1; ofs_sel = sel;
        w_cs_n = 1'b1; w_en = 1'b0; r_cs_n = 1'b1; r_en = 1'b0;
        repeat (4) @(posedge clk_r);
        #0.2;
        chk("R3", "full_n in reset",   64'(full_n),   64'd0);
        chk("R3", "afull_n in reset",  64'(afull_n),  64'd0);
        chk("R3", "empty_n in reset",  64'(empty_n),  64'd0);
        chk("R3", "aempty_n in reset", 64'(aempty_n), 64'd0);
        chk("R3", "r_data in reset",   64'(r_data),   64'd0);
        exp_q.delete();
        @(negedge clk_w);
        rst = 1'b0;
        @(posedge clk_w); #0.2;
        chk("R3", "full_n after 1st wclk edge", 64'(full_n), 64'd0);
        @(posedge clk_w); #0.2;
        chk("R3", "full_n after 2nd wclk edge", 64'(full_n), 64'd1);
        repeat (6) @(posedge clk_r);
        #0.2;
        chk("R3", "empty_n after reset", 64'(empty_n), 64'd0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // scoreboard monitor: every accepted read must match the oldest stored word (R2)
    initial begin
        forever begin
            logic go;
            @(posedge clk_r);
            go = !r_cs_n && r_en && empty_n && !rst;
            #0.2;
            if (go) begin
                if (exp_q.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL R2 read with no stored word: actual=%0h expected=none", r_data);
                end else begin
                    logic [35:0] e;
                    e = exp_q.pop_front();
                    chk("R2", "read order", 64'(r_data), 64'(e));
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk_w);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        do_reset(2'b00);   // X = 16
        chk("R8", "afull_n when empty", 64'(afull_n), 64'd1);

        // R6: empty_n rises on the second read edge after the write
        wr(36'hA_5A5A_0001, 1'b0, 1'b1);
        @(posedge clk_r); #0.2;
        chk("R6", "empty_n 1st rclk edge", 64'(empty_n), 64'd0);
        @(posedge clk_r); #0.2;
        chk("R6", "empty_n 2nd rclk edge", 64'(empty_n), 64'd1);
        chk("R7", "aempty_n at count 1", 64'(aempty_n), 64'd0);
        rd();
        chk("R5", "empty_n after last read", 64'(empty_n), 64'd0);

        // R1: gated writes store nothing
        wr(36'hF_FFFF_0001, 1'b1, 1'b1);
        wr(36'hF_FFFF_0002, 1'b0, 1'b0);
        repeat (5) @(posedge clk_r);
        #0.2;
        chk("R1", "empty_n after gated writes", 64'(empty_n), 64'd0);

        // R1: gated reads take nothing
        wr(36'h5_A5A5_0002, 1'b0, 1'b1);
        repeat (4) @(posedge clk_r);
        @(negedge clk_r); r_cs_n = 1'b1; r_en = 1'b1;
        @(posedge clk_r); #0.2;
        chk("R1", "r_data after deselected read", 64'(r_data), 64'h0_0000_000A_5A5A_0001 & 64'hF_FFFF_FFFF);
        @(negedge clk_r); r_cs_n = 1'b0; r_en = 1'b0;
        @(posedge clk_r); #0.2;
        r_cs_n = 1'b1;
        chk("R1", "r_data after disabled read", 64'(r_data), 64'hA_5A5A_0001);
        chk("R1", "word kept after gated reads", 64'(empty_n), 64'd1);
        rd();
        repeat (4) @(posedge clk_w);

        // R4, R8: fill to 64 words
        for (int i = 1; i <= 64; i++) begin
            wr(36'h9_0000_0000 | 36'(i), 1'b0, 1'b1);
            if (i == 47) chk("R8", "afull_n at free 17", 64'(afull_n), 64'd1);
            if (i == 48) chk("R8", "afull_n at free 16", 64'(afull_n), 64'd0);
            if (i == 63) chk("R4", "full_n at 63 words", 64'(full_n), 64'd1);
            if (i == 64) chk("R4", "full_n at 64 words", 64'(full_n), 64'd0);
        end
        wr(36'h7_7777_7777, 1'b0, 1'b1);
        chk("R4", "full_n after dropped write", 64'(full_n), 64'd0);
        repeat (4) @(posedge clk_r);
        #0.2;
        chk("R7", "aempty_n at count 64", 64'(aempty_n), 64'd1);

        // R10: full_n rises on the second write edge after a read
        @(negedge clk_r); r_cs_n = 1'b0; r_en = 1'b1;
        @(posedge clk_r); #0.2;
        r_cs_n = 1'b1; r_en = 1'b0;
        @(posedge clk_w); #0.2;
        chk("R10", "full_n 1st wclk edge", 64'(full_n), 64'd0);
        @(posedge clk_w); #0.2;
        chk("R10", "full_n 2nd wclk edge", 64'(full_n), 64'd1);

        // drain, tracking the almost-empty boundary (R7)
        for (int k = 62; k >= 0; k--) begin
            rd();
            if (k == 17 || k == 16 || k == 0)
                chk("R7", $sformatf("aempty_n at count %0d", k), 64'(aempty_n), 64'(k > 16));
        end
        chk("R5", "empty_n after drain", 64'(empty_n), 64'd0);
        rd();
        chk("R5", "r_data after read on empty", 64'(r_data), 64'h9_0000_0040);

        // R9: code 11 gives X = 4; later change of ofs_sel ignored
        do_reset(2'b11);
        ofs_sel = 2'b00;
        for (int i = 1; i <= 60; i++) begin
            wr(36'(i), 1'b0, 1'b1);
            if (i == 59) chk("R9", "afull_n at free 5, code 11", 64'(afull_n), 64'd1);
            if (i == 60) chk("R9", "afull_n at free 4, code 11", 64'(afull_n), 64'd0);
        end

        // R9: code 10 gives X = 8
        do_reset(2'b10);
        for (int i = 1; i <= 8; i++) wr(36'(i), 1'b0, 1'b1);
        repeat (4) @(posedge clk_r);
        #0.2;
        chk("R9", "aempty_n at count 8, code 10", 64'(aempty_n), 64'd0);
        wr(36'd9, 1'b0, 1'b1);
        repeat (4) @(posedge clk_r);
        #0.2;
        chk("R9", "aempty_n at count 9, code 10", 64'(aempty_n), 64'd1);

        // R9: code 01 gives X = 12
        do_reset(2'b01);
        for (int i = 1; i <= 52; i++) begin
            wr(36'(i), 1'b0, 1'b1);
            if (i == 51) chk("R9", "afull_n at free 13, code 01", 64'(afull_n), 64'd1);
            if (i == 52) chk("R9", "afull_n at free 12, code 01", 64'(afull_n), 64'd0);
        end

        finish_run();
    end
endmodule